// File: doc/BRIEF.md
# Synchronous Differential Clock Stop Controller

This block gates a group of differential clock pairs driven from a free-running source clock. Each pair is modelled as a true leg, a complement leg and a separate output enable for each leg. An active-low stop input parks the pairs that a stoppable mask selects and leaves every other pair running. An active-low power-down input parks every pair, whatever the mask says. Two configuration bits choose whether a parked pair is driven or tri-stated, one bit for stop and one for power-down.

Both requests pass through a synchronizer on the falling edge of the source clock. The park decision is registered on the rising edge, while the true leg is high. A parked pair therefore holds its true leg high, which keeps the level of the high phase in progress. When the pair restarts, the true leg simply continues that high phase. No pulse is cut short or added.

The complement leg is released while parked and reads low through an external pull-down, which the model shows as value 0 with its enable low. A tri-stated true leg is modelled the same way.

Top module: `diffclk_stop_ctrl`

## Requirements
- R1: While the stop input is low and power-down is inactive, only pairs whose latched mask bit is 1 park. A pair with mask bit 0 keeps toggling with both enables high.
- R2: After the stop input falls during a high phase of the source clock, a masked true output shows exactly two more low phases and then stays parked.
- R3: A pair parked in driven mode shows true = 1 with its enable high, and complement = 0 with its enable low.
- R4: After a restart, every high and low phase of the true output lasts exactly half a source period.
- R5: A pair restarts on the second rising source edge after the stop input returns high. Its first falling edge comes no more than two and a half source periods after the deassertion.
- R6: A parked pair is tri-stated (all four pins read 0, both enables low) when the bit selecting tri-state for its cause is 1. The tri-on-power-down bit applies while power-down is active; otherwise the tri-on-stop bit applies.
- R7: Power-down parks every pair regardless of the mask, and it takes priority over the stop input.
- R8: The stoppable mask is latched only while the stop request is inactive. A mask change made while stop is held changes no pair.
- R9: While reset is low, every pair runs: true follows the source clock, complement is its inverse, and both enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Free-running source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_n | input | 1 | Active-low stop request |
| pwrdn_n | input | 1 | Active-low power-down request |
| stop_mask | input | NUM_PAIRS | 1 = pair is stoppable |
| tri_on_stop | input | 1 | 1 = tri-state pairs parked by stop |
| tri_on_pwrdn | input | 1 | 1 = tri-state pairs parked by power-down |
| clk_t | output | NUM_PAIRS | True leg of each pair |
| clk_c | output | NUM_PAIRS | Complement leg of each pair |
| oe_t | output | NUM_PAIRS | Drive enable of each true leg |
| oe_c | output | NUM_PAIRS | Drive enable of each complement leg |

## Verification
A fault in the synchronizer shows up as the wrong number of low phases on a true leg after stop falls. The same fault also moves the first restart edge, and both are visible within three source periods. A wrong park flag or a wrong mask latch shows up at the first rising edge after the request settles: a pair parks that should not, or keeps toggling that should park. A wrong tri-state selection appears in the enables on that same edge. A gating update applied outside the high phase shows up as a short or long phase, and it is caught by timing each phase after a restart.

// File: rtl/ckstp_pkg.sv
package ckstp_pkg;
    typedef struct packed {
        logic parked;
        logic tristate;
    } lane_st_t;

    localparam lane_st_t LANE_RUN = '{parked: 1'b0, tristate: 1'b0};
endpackage

// File: rtl/ckstp_sync.sv
module ckstp_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_n,
    output logic [W-1:0] req
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_n;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(negedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '1;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    // request is active once the last stage has sampled a low level
    assign req = ~stage_q[LAST];
endmodule

// File: rtl/ckstp_lane.sv
module ckstp_lane
    import ckstp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic pd_req,
    input  logic stoppable,
    input  logic tri_stop,
    input  logic tri_pd,
    output logic pin_t,
    output logic pin_c,
    output logic en_t,
    output logic en_c
);
    lane_st_t st_d, st_q;

    always_comb begin
        st_d.parked   = pd_req | (stop_req & stoppable);
        st_d.tristate = st_d.parked & (pd_req ? tri_pd : tri_stop);
    end

    // rising edge: the true leg is high, so parking high never cuts a phase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= LANE_RUN;
        else        st_q <= st_d;
    end

    always_comb begin
        if (!st_q.parked) begin
            pin_t = clk;
            pin_c = ~clk;
            en_t  = 1'b1;
            en_c  = 1'b1;
        end else if (st_q.tristate) begin
            pin_t = 1'b0;
            pin_c = 1'b0;
            en_t  = 1'b0;
            en_c  = 1'b0;
        end else begin
            pin_t = 1'b1;
            pin_c = 1'b0;
            en_t  = 1'b1;
            en_c  = 1'b0;
        end
    end
endmodule

// File: rtl/diffclk_stop_ctrl.sv
module diffclk_stop_ctrl #(
    parameter int NUM_PAIRS   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk_src,
    input  logic                 rst_n,
    input  logic                 stop_n,
    input  logic                 pwrdn_n,
    input  logic [NUM_PAIRS-1:0] stop_mask,
    input  logic                 tri_on_stop,
    input  logic                 tri_on_pwrdn,
    output logic [NUM_PAIRS-1:0] clk_t,
    output logic [NUM_PAIRS-1:0] clk_c,
    output logic [NUM_PAIRS-1:0] oe_t,
    output logic [NUM_PAIRS-1:0] oe_c
);
    localparam int REQ_W = 2;

    logic [REQ_W-1:0]     req_vec;
    logic                 stop_req;
    logic                 pd_req;
    logic [NUM_PAIRS-1:0] mask_d, mask_q;

    ckstp_sync #(.W(REQ_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_src),
        .rst_n   (rst_n),
        .async_n ({pwrdn_n, stop_n}),
        .req     (req_vec)
    );

    assign stop_req = req_vec[0];
    assign pd_req   = req_vec[1];

    // the mask is frozen while a stop is pending
    always_comb begin
        mask_d = stop_req ? mask_q : stop_mask;
    end

    always_ff @(posedge clk_src or negedge rst_n) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    generate
        for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_lane
            ckstp_lane u_lane (
                .clk       (clk_src),
                .rst_n     (rst_n),
                .stop_req  (stop_req),
                .pd_req    (pd_req),
                .stoppable (mask_q[i]),
                .tri_stop  (tri_on_stop),
                .tri_pd    (tri_on_pwrdn),
                .pin_t     (clk_t[i]),
                .pin_c     (clk_c[i]),
                .en_t      (oe_t[i]),
                .en_c      (oe_c[i])
            );
        end
    endgenerate
endmodule

// File: rtl/ckstp_chk.sv
module ckstp_chk #(
    parameter int NUM_PAIRS = 4
) (
    input logic                 clk_src,
    input logic                 rst_n,
    input logic                 stop_req,
    input logic                 pd_req,
    input logic                 tri_on_pwrdn,
    input logic [NUM_PAIRS-1:0] mask_q,
    input logic [NUM_PAIRS-1:0] clk_t,
    input logic [NUM_PAIRS-1:0] clk_c,
    input logic [NUM_PAIRS-1:0] oe_t,
    input logic [NUM_PAIRS-1:0] oe_c
);
    p_mask_frozen_r8: assert property (@(posedge clk_src) disable iff (!rst_n)
        stop_req && $past(stop_req) |-> $stable(mask_q));

    p_pd_parks_all_r7: assert property (@(posedge clk_src) disable iff (!rst_n)
        pd_req |=> (oe_c == '0));

    p_pd_tristate_r6: assert property (@(posedge clk_src) disable iff (!rst_n)
        pd_req && tri_on_pwrdn |=> (oe_t == '0));

    p_resume_r5: assert property (@(posedge clk_src) disable iff (!rst_n)
        !stop_req && !pd_req |=> (oe_c == '1));

    generate
        for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_chk
            p_unmasked_run_r1: assert property (@(posedge clk_src) disable iff (!rst_n)
                !pd_req && !mask_q[i] |=> oe_t[i] && oe_c[i]);

            p_park_high_r3: assert property (@(posedge clk_src) disable iff (!rst_n)
                oe_t[i] && !oe_c[i] |-> clk_t[i] && !clk_c[i]);
        end
    endgenerate
endmodule

bind diffclk_stop_ctrl ckstp_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
    .clk_src      (clk_src),
    .rst_n        (rst_n),
    .stop_req     (stop_req),
    .pd_req       (pd_req),
    .tri_on_pwrdn (tri_on_pwrdn),
    .mask_q       (mask_q),
    .clk_t        (clk_t),
    .clk_c        (clk_c),
    .oe_t         (oe_t),
    .oe_c         (oe_c)
);

// File: tb/test_diffclk_stop_ctrl.sv
`timescale 1ns/1ps
module test_diffclk_stop_ctrl;
    localparam int NP = 4;
    localparam int NV = 10;

    logic          clk_src = 1'b0;
    logic          rst_n = 1'b0;
    logic          stop_n = 1'b1;
    logic          pwrdn_n = 1'b1;
    logic [NP-1:0] stop_mask = 4'b0011;
    logic          tri_on_stop = 1'b0;
    logic          tri_on_pwrdn = 1'b0;
    logic [NP-1:0] clk_t, clk_c, oe_t, oe_c;

    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    always #2.5 clk_src = ~clk_src;

    diffclk_stop_ctrl #(.NUM_PAIRS(NP)) i_diffclk_stop_ctrl (
        .clk_src(clk_src), .rst_n(rst_n), .stop_n(stop_n), .pwrdn_n(pwrdn_n),
        .stop_mask(stop_mask), .tri_on_stop(tri_on_stop), .tri_on_pwrdn(tri_on_pwrdn),
        .clk_t(clk_t), .clk_c(clk_c), .oe_t(oe_t), .oe_c(oe_c)
    );

    // row: stop_n, pwrdn_n, mask[3:0], tri_on_stop, tri_on_pwrdn, expected lane codes
    // lane code (2 bits, lane i at [2i+1:2i]): 0 run, 1 parked driven, 2 tri-state
    localparam logic [15:0] VEC [NV] = '{
        {1'b1, 1'b1, 4'b0011, 1'b0, 1'b0, 8'h00},
        {1'b0, 1'b1, 4'b0011, 1'b0, 1'b0, 8'h05},
        {1'b0, 1'b1, 4'b1100, 1'b0, 1'b0, 8'h05},
        {1'b1, 1'b1, 4'b1100, 1'b0, 1'b0, 8'h00},
        {1'b0, 1'b1, 4'b1100, 1'b0, 1'b0, 8'h50},
        {1'b0, 1'b1, 4'b1100, 1'b1, 1'b0, 8'hA0},
        {1'b0, 1'b0, 4'b1100, 1'b1, 1'b0, 8'h55},
        {1'b0, 1'b0, 4'b1100, 1'b1, 1'b1, 8'hAA},
        {1'b1, 1'b0, 4'b0000, 1'b0, 1'b1, 8'hAA},
        {1'b1, 1'b1, 4'b0000, 1'b0, 1'b0, 8'h00}
    };

    function automatic string row_tag(int i);
        case (i)
            0:       return "R1";
            1:       return "R1,R3";
            2:       return "R8";
            3:       return "R5";
            4:       return "R8,R3";
            5:       return "R6";
            6:       return "R7,R6";
            7:       return "R6,R7";
            8:       return "R7";
            default: return "R1,R7";
        endcase
    endfunction

    // read at mid-low phase of the source clock
    function automatic logic [7:0] observe();
        logic [7:0] o;
        for (int i = 0; i < NP; i++) begin
            if (oe_t[i] && oe_c[i] && !clk_t[i] && clk_c[i])       o[2*i +: 2] = 2'd0;
            else if (oe_t[i] && !oe_c[i] && clk_t[i] && !clk_c[i]) o[2*i +: 2] = 2'd1;
            else if (!oe_t[i] && !oe_c[i] && !clk_t[i] && !clk_c[i]) o[2*i +: 2] = 2'd2;
            else                                                   o[2*i +: 2] = 2'd3;
        end
        return o;
    endfunction

    task automatic check(input bit ok, input string tag, input real act, input real exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0g expected=%0g", tag, act, exp);
        end
    endtask

    task automatic at_pos();
        @(posedge clk_src);
        #1;
    endtask

    task automatic at_low();
        @(negedge clk_src);
        #1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        logic [7:0] got;
        int   low0, low1;
        real  t0, t1, tp;

        // R9: reset state, all pairs running
        repeat (2) at_low();
        got = observe();
        check(got == 8'h00, "R9", real'(got), 0.0);
        at_pos();
        rst_n = 1'b1;
        repeat (3) at_pos();

        // table of patterns
        for (int v = 0; v < NV; v++) begin
            {stop_n, pwrdn_n, stop_mask, tri_on_stop, tri_on_pwrdn} = VEC[v][15:8];
            repeat (4) at_pos();
            at_low();
            got = observe();
            check(got == VEC[v][7:0], row_tag(v), real'(got), real'(VEC[v][7:0]));
        end

        // R2: two low phases after stop falls; R1: unmasked pair keeps toggling
        at_pos();
        stop_mask = 4'b0001;
        repeat (3) at_pos();
        stop_n = 1'b0;
        low0 = 0;
        low1 = 0;
        for (int k = 0; k < 6; k++) begin
            at_low();
            if (!clk_t[0]) low0++;
            if (!clk_t[1]) low1++;
        end
        check(low0 == 2, "R2", real'(low0), 2.0);
        check(low1 == 6, "R1", real'(low1), 6.0);
        got = observe();
        check(got == 8'h01, "R3", real'(got), 1.0);

        // R5: restart latency; R4: phase widths after restart
        at_pos();
        stop_n = 1'b1;
        t0 = $realtime;
        @(negedge clk_t[0]);
        t1 = $realtime;
        check((t1 - t0) <= 12.5 && (t1 - t0) >= 7.5, "R5", t1 - t0, 11.5);
        for (int k = 0; k < 2; k++) begin
            tp = $realtime;
            @(posedge clk_t[0]);
            check(($realtime - tp) > 2.49 && ($realtime - tp) < 2.51, "R4 low", $realtime - tp, 2.5);
            tp = $realtime;
            @(negedge clk_t[0]);
            check(($realtime - tp) > 2.49 && ($realtime - tp) < 2.51, "R4 high", $realtime - tp, 2.5);
        end

        done = 1'b1;
        finish_run();
    end
endmodule